// File: doc/BRIEF.md
# Sequenced-Disable Watchdog Timer

This block is a supervisory timer. It needs no software action to start: it is armed as soon as reset is released. From then on it counts prescaled ticks, and software must restart it before the count wraps. The first missed deadline raises a sticky timeout flag. A second missed deadline, while the flag is still set, raises a system reset request.

The timer can be switched off, but only through a deliberate two-step sequence: a disable strobe, then a restart strobe as the very next command. Any other command in between cancels the attempt. Whenever the system comes back from its low-power backup state, a one-cycle return pulse re-arms the timer and clears its count, even if it had been switched off.

Commands arrive as single-cycle strobes synchronous to the clock. The prescaled tick is a one-cycle enable.

Top module: `wdog_seq`

## Requirements
- R1: After reset, `wdFlag` and `resetReq` are 0 and the timer is already armed: with no command given, `wdFlag` rises after exactly 2^CNT_W ticks.
- R2: While armed, the internal count goes up by one on each cycle with `tick` high. Reaching the all-ones value and then taking one more tick is a wrap event, and the count returns to zero.
- R3: A wrap event while `wdFlag` is 0 sets `wdFlag` in the cycle after that tick and leaves `resetReq` at 0.
- R4: A wrap event while `wdFlag` is 1 sets `resetReq`. `resetReq` then stays at 1 until reset.
- R5: `restartCmd` clears the count to zero. If it arrives in the same cycle as the tick that would wrap, no wrap event occurs.
- R6: `flagClr` clears `wdFlag`. A wrap event in the same cycle takes priority and leaves the flag set.
- R7: If `disableCmd` is followed by `restartCmd`, with no other command strobe in between (idle cycles are allowed), the timer stops. While stopped, no number of ticks changes `wdFlag` or `resetReq`.
- R8: A `disableCmd` followed by any other command (`flagClr`, or a return pulse) before the restart has no effect, and a later restart only clears the count. A disable and a restart in the same cycle do not stop the timer; that disable waits for the next restart.
- R9: `backupRet` re-arms the timer, clears its count and drops any pending disable. It leaves `wdFlag` and `resetReq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count enable, one cycle wide |
| disableCmd | input | 1 | First step of the stop sequence |
| restartCmd | input | 1 | Restart strobe: clears the count and completes the stop sequence |
| flagClr | input | 1 | Clears the timeout flag |
| backupRet | input | 1 | Pulse on return from the backup state |
| wdFlag | output | 1 | Sticky timeout flag |
| resetReq | output | 1 | System reset request, held until reset |

## Verification
The assertions assume every command and tick is a clean, synchronous single-cycle level, and that `rstN` is the only thing that clears `resetReq`. They also assume the stop sequence is judged by command order, not by cycle distance. The stimulus drives all strobes at the falling edge from a seeded `$urandom` stream and keeps each strobe rare, so that wraps, restarts and partial stop sequences all appear. It holds return pulses to a low rate, so that stopped intervals last long enough to show that ticks are ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from control to the count datapath.
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } cntCmd_t;
endpackage

// File: rtl/wdog_count.sv
module wdog_count import wdog_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCmd_t cmd,
  output logic    atMax
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= CNT_ZERO;
    else if (cmd.clrCnt) cnt <= CNT_ZERO;
    else if (cmd.incCnt) cnt <= cnt + 1'b1;
  end

  assign atMax = &cnt;

  // A clear request always leaves the count at zero (R5).
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrCnt |=> (cnt == CNT_ZERO));

  // An increment from all-ones wraps to zero (R2).
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.incCnt && !cmd.clrCnt && atMax) |=> (cnt == CNT_ZERO));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl import wdog_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    disableCmd,
  input  logic    restartCmd,
  input  logic    flagClr,
  input  logic    backupRet,
  input  logic    atMax,
  output cntCmd_t cmd,
  output logic    wdFlag,
  output logic    resetReq
);
  logic enQ, pendQ, flagQ, rrQ;
  logic wrapEv;

  assign wrapEv     = enQ & tick & atMax & ~restartCmd & ~backupRet;
  assign cmd.clrCnt = restartCmd | backupRet | ~enQ;
  assign cmd.incCnt = enQ & tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b1;
      pendQ <= 1'b0;
    end else if (backupRet) begin
      enQ   <= 1'b1;
      pendQ <= 1'b0;
    end else begin
      if (restartCmd && pendQ) enQ <= 1'b0;
      if (disableCmd)                 pendQ <= 1'b1;
      else if (restartCmd || flagClr) pendQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      rrQ   <= 1'b0;
    end else begin
      if (wrapEv)       flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
      if (wrapEv && flagQ) rrQ <= 1'b1;
    end
  end

  assign wdFlag   = flagQ;
  assign resetReq = rrQ;

  // The timer stops only on a restart that found a disable pending (R7).
  p_stop_needs_seq_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enQ) |-> ($past(restartCmd) && $past(pendQ)));

  // A return pulse re-arms and drops the pending disable (R9).
  p_backup_rearm_r9: assert property (@(posedge clk) disable iff (!rstN)
    backupRet |=> (enQ && !pendQ));

  // A reset request needs the flag to have been set first (R4).
  p_reset_after_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(wdFlag));

  // Once raised, the reset request holds (R4).
  p_reset_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq);

  // The flag rises only after an armed tick at the top of the count (R3).
  p_flag_on_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> $past(enQ && tick && atMax));
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq import wdog_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic disableCmd,
  input  logic restartCmd,
  input  logic flagClr,
  input  logic backupRet,
  output logic wdFlag,
  output logic resetReq
);
  cntCmd_t cntCmd;
  logic    atMax;

  wdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .disableCmd(disableCmd),
    .restartCmd(restartCmd), .flagClr(flagClr), .backupRet(backupRet),
    .atMax(atMax), .cmd(cntCmd), .wdFlag(wdFlag), .resetReq(resetReq)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .cmd(cntCmd), .atMax(atMax)
  );
endmodule

// File: tb/sim_wdog_seq.sv
module sim_wdog_seq;
  localparam int W = 4;
  localparam int PERIOD = 1 << W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, disableCmd = 1'b0, restartCmd = 1'b0;
  logic flagClr = 1'b0, backupRet = 1'b0;
  logic wdFlag, resetReq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;
  string curTag = "R1";

  // Requirement-level model state
  bit mEn, mPend, mFlag, mRr;
  int mCnt;

  always #4 clk = ~clk;

  wdog_seq #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .disableCmd(disableCmd),
    .restartCmd(restartCmd), .flagClr(flagClr), .backupRet(backupRet),
    .wdFlag(wdFlag), .resetReq(resetReq)
  );

  task automatic check(string tag, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  function automatic bit wrapOf(bit t, bit r, bit b);
    return mEn && t && (mCnt == PERIOD - 1) && !r && !b;
  endfunction

  task automatic modelStep(bit t, bit d, bit r, bit f, bit b);
    bit wrap = wrapOf(t, r, b);
    bit enNow = mEn;
    if (wrap && mFlag) mRr = 1'b1;
    if (wrap) mFlag = 1'b1; else if (f) mFlag = 1'b0;
    if (b || r || !enNow) mCnt = 0;
    else if (t) mCnt = (mCnt + 1) % PERIOD;
    if (b) begin mEn = 1'b1; mPend = 1'b0; end
    else begin
      if (r && mPend) mEn = 1'b0;
      if (d) mPend = 1'b1; else if (r || f) mPend = 1'b0;
    end
  endtask

  // Called at a falling edge; returns at the next falling edge and compares.
  task automatic step(bit t, bit d, bit r, bit f, bit b);
    tick = t; disableCmd = d; restartCmd = r; flagClr = f; backupRet = b;
    modelStep(t, d, r, f, b);
    @(negedge clk);
    tick = 0; disableCmd = 0; restartCmd = 0; flagClr = 0; backupRet = 0;
    check(curTag, "wdFlag", wdFlag, mFlag);
    check("R4", "resetReq", resetReq, mRr);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    mEn = 1'b1; mPend = 1'b0; mFlag = 1'b0; mRr = 1'b0; mCnt = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    doReset();
    // R1: reset state, timer already armed
    check("R1", "wdFlag after reset", wdFlag, 1'b0);
    check("R1", "resetReq after reset", resetReq, 1'b0);
    curTag = "R2";
    ticks(PERIOD - 1);
    check("R2", "no wrap before full period", wdFlag, 1'b0);
    ticks(1);
    check("R3", "first wrap sets flag", wdFlag, 1'b1);
    check("R3", "first wrap no reset", resetReq, 1'b0);
    ticks(PERIOD);
    check("R4", "second wrap requests reset", resetReq, 1'b1);
    ticks(3);
    check("R4", "reset request held", resetReq, 1'b1);

    // R5: restart on the wrapping tick blocks the wrap
    doReset(); curTag = "R5";
    ticks(PERIOD - 1);
    step(1, 0, 1, 0, 0);
    check("R5", "restart with final tick", wdFlag, 1'b0);
    ticks(PERIOD - 1);
    check("R5", "count restarted from zero", wdFlag, 1'b0);

    // R6: flag clear, and wrap beating clear
    ticks(1);
    check("R6", "flag set before clear", wdFlag, 1'b1);
    step(0, 0, 0, 1, 0);
    check("R6", "flag cleared", wdFlag, 1'b0);
    ticks(PERIOD - 1);
    step(1, 0, 0, 1, 0);
    check("R6", "wrap wins over clear", wdFlag, 1'b1);
    check("R6", "flag was clear so no reset", resetReq, 1'b0);

    // R8: broken sequence has no effect
    doReset(); curTag = "R8";
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0);
    ticks(PERIOD);
    check("R8", "interrupted disable ignored", wdFlag, 1'b1);
    doReset();
    step(0, 1, 1, 0, 0);
    ticks(PERIOD);
    check("R8", "same-cycle disable and restart", wdFlag, 1'b1);

    // R7: disable, idle, restart stops the timer
    doReset(); curTag = "R7";
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    ticks(3 * PERIOD);
    check("R7", "stopped timer no flag", wdFlag, 1'b0);
    check("R7", "stopped timer no reset", resetReq, 1'b0);

    // R9: return pulse re-arms
    curTag = "R9";
    step(0, 0, 0, 0, 1);
    ticks(PERIOD - 1);
    check("R9", "re-armed count from zero", wdFlag, 1'b0);
    ticks(1);
    check("R9", "re-armed timer wraps", wdFlag, 1'b1);
    step(0, 0, 0, 0, 1);
    check("R9", "return keeps flag", wdFlag, 1'b1);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 1, 0, 0);
    ticks(PERIOD);
    check("R9", "return drops pending disable", resetReq, 1'b1);

    // Random phase, compared against the model each cycle
    doReset(); curTag = "R2";
    for (int i = 0; i < 4000; i++) begin
      bit t = ($urandom % 4) != 0;
      bit d = ($urandom % 40) == 0;
      bit r = ($urandom % 24) == 0;
      bit f = ($urandom % 30) == 0;
      bit b = ($urandom % 150) == 0;
      if (($urandom % 500) == 0) doReset();
      step(t, d, r, f, b);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule